// File: doc/BRIEF.md
# Double-Buffered Fine-Resolution PWM Generator

This block produces a single pulse-width-modulated output from an 8-bit timebase. The timebase is clocked by a selectable prescaler (divide by 1, 4 or 16). A 2-bit fine counter sits beneath the 8-bit timer, and the timer advances each time the fine counter wraps. One PWM period therefore lasts (period + 1) × 4 × prescale input clocks. The duty value is 10 bits wide and is compared against the timer joined with the fine counter. This gives the output two bits more resolution than the timer alone.

Software programs the block through a small register bus. The 10-bit duty value is written as an 8-bit upper part and a 2-bit lower part, and it can be changed at any moment. The block copies the pending duty into a shadow register only at the period rollover, so a period in progress is never cut short or stretched. A one-cycle strobe marks each period start. The shadow value can be read back but cannot be written.

Top module: `dbuf_pwm`

## Requirements
- R1: While reset is held, and in the first cycle after it, `pwm_o` and `period_strobe_o` are low and every register at addresses 0 to 5 reads back 0.
- R2: Register map (3-bit address): 0 is the period, 1 is duty bits [9:2], 2 is duty bits [1:0] in data bits [1:0], and 3 is control. In the control register bit 0 is enable and bits [2:1] are the prescale select. Addresses 0 to 3 read back what was written.
- R3: While enabled, `period_strobe_o` pulses for one cycle every (period + 1) × 4 × D clocks. D is 1 for select 0, 4 for select 1, and 16 for select 2 or 3.
- R4: `pwm_o` rises in the same cycle as `period_strobe_o` and stays high for duty × D clocks.
- R5: A duty written during a period takes effect only from the next strobe. A write captured on the same edge as the rollover is held back one more period. The shadow keeps its old value until it is reloaded.
- R6: A shadow duty of 0 keeps `pwm_o` low for the whole period.
- R7: A duty of 4 × (period + 1) or more keeps `pwm_o` high for the whole period.
- R8: While enable is 0, `pwm_o` and `period_strobe_o` stay low and the timebase is held at zero.
- R9: The shadow duty reads back at addresses 4 (bits [9:2]) and 5 (bits [1:0]). Writes to those addresses are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| pwm_o | output | 1 | PWM output |
| period_strobe_o | output | 1 | One-cycle pulse at each period start |

## Verification
A duty-register write and the period rollover can land on the same clock edge. The bench provokes this by counting cycles from a strobe and issuing the write exactly one period minus one cycle later. It then checks that the following period still carries the old duty and that the period after it carries the new one. The set of the output at rollover and the compare clear also collide when the duty is 0 or at least the full period length. Those cases are judged by the high-time count over a full period, which must come out at 0 or at the whole period.

// File: rtl/dbuf_pwm_pkg.sv
package dbuf_pwm_pkg;
    parameter int unsigned ADDR_W = 3;
    parameter int unsigned SEL_W  = 2;

    typedef enum logic [ADDR_W-1:0] {
        A_PERIOD  = 3'd0,
        A_DUTY_HI = 3'd1,
        A_DUTY_LO = 3'd2,
        A_CTRL    = 3'd3,
        A_SHAD_HI = 3'd4,
        A_SHAD_LO = 3'd5
    } reg_addr_e;

    localparam int unsigned CTRL_EN_BIT  = 0;
    localparam int unsigned CTRL_SEL_LSB = 1;
endpackage

// File: rtl/dbuf_pwm_regs.sv
module dbuf_pwm_regs
    import dbuf_pwm_pkg::*;
#(
    parameter int unsigned TMR_W  = 8,
    parameter int unsigned FINE_W = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [TMR_W-1:0]         wdata,
    input  logic [TMR_W+FINE_W-1:0]  shadow,
    output logic [TMR_W-1:0]         rdata,
    output logic [TMR_W-1:0]         period,
    output logic [TMR_W+FINE_W-1:0]  duty_pend,
    output logic                     en,
    output logic [SEL_W-1:0]         sel
);
    typedef struct packed {
        logic [TMR_W-1:0]  period;
        logic [TMR_W-1:0]  duty_hi;
        logic [FINE_W-1:0] duty_lo;
        logic              en;
        logic [SEL_W-1:0]  sel;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr) begin
            case (reg_addr_e'(addr))
                A_PERIOD:  r_d.period  = wdata;
                A_DUTY_HI: r_d.duty_hi = wdata;
                A_DUTY_LO: r_d.duty_lo = wdata[FINE_W-1:0];
                A_CTRL: begin
                    r_d.en  = wdata[CTRL_EN_BIT];
                    r_d.sel = wdata[CTRL_SEL_LSB +: SEL_W];
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        rdata = '0;
        case (reg_addr_e'(addr))
            A_PERIOD:  rdata = r_q.period;
            A_DUTY_HI: rdata = r_q.duty_hi;
            A_DUTY_LO: rdata[FINE_W-1:0] = r_q.duty_lo;
            A_CTRL: begin
                rdata[CTRL_EN_BIT]            = r_q.en;
                rdata[CTRL_SEL_LSB +: SEL_W]  = r_q.sel;
            end
            A_SHAD_HI: rdata = shadow[TMR_W+FINE_W-1:FINE_W];
            A_SHAD_LO: rdata[FINE_W-1:0] = shadow[FINE_W-1:0];
            default:   rdata = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign period    = r_q.period;
    assign duty_pend = {r_q.duty_hi, r_q.duty_lo};
    assign en        = r_q.en;
    assign sel       = r_q.sel;
endmodule

// File: rtl/dbuf_pwm_prescale.sv
module dbuf_pwm_prescale
    import dbuf_pwm_pkg::*;
#(
    parameter int unsigned PS_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    typedef struct packed {
        logic [PS_W-1:0]  cnt;
        logic [SEL_W-1:0] sel_prev;
    } ps_t;

    ps_t p_d, p_q;
    logic [PS_W-1:0] div_m1;

    always_comb begin
        case (sel)
            2'd0:    div_m1 = '0;
            2'd1:    div_m1 = PS_W'(3);
            default: div_m1 = PS_W'(15);
        endcase
    end

    always_comb begin
        p_d          = p_q;
        p_d.sel_prev = sel;
        tick         = 1'b0;
        if (!en || sel != p_q.sel_prev) begin
            p_d.cnt = '0;
        end else if (p_q.cnt == div_m1) begin
            p_d.cnt = '0;
            tick    = 1'b1;
        end else begin
            p_d.cnt = p_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end
endmodule

// File: rtl/dbuf_pwm_timebase.sv
module dbuf_pwm_timebase #(
    parameter int unsigned TMR_W  = 8,
    parameter int unsigned FINE_W = 2,
    localparam int unsigned CNT_W = TMR_W + FINE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             tick,
    input  logic [TMR_W-1:0] period,
    output logic [CNT_W-1:0] cnt_next,
    output logic             rollover
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d    = cnt_q;
        rollover = 1'b0;
        if (!en) begin
            cnt_d = '0;
        end else if (tick) begin
            if (cnt_q == {period, {FINE_W{1'b1}}}) begin
                cnt_d    = '0;
                rollover = 1'b1;
            end else begin
                cnt_d = cnt_q + 1'b1;
            end
        end
        cnt_next = cnt_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/dbuf_pwm_out.sv
module dbuf_pwm_out #(
    parameter int unsigned DUTY_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              step,
    input  logic              rollover,
    input  logic [DUTY_W-1:0] cnt_next,
    input  logic [DUTY_W-1:0] duty_pend,
    output logic [DUTY_W-1:0] shadow,
    output logic              pwm,
    output logic              strobe
);
    typedef struct packed {
        logic              pwm;
        logic              strobe;
        logic [DUTY_W-1:0] shadow;
    } out_t;

    out_t o_d, o_q;

    always_comb begin
        o_d        = o_q;
        o_d.strobe = 1'b0;
        if (!en) begin
            o_d.pwm = 1'b0;
        end else if (rollover) begin
            o_d.shadow = duty_pend;
            o_d.pwm    = (duty_pend != '0);
            o_d.strobe = 1'b1;
        end else if (step && cnt_next == o_q.shadow) begin
            o_d.pwm = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    assign shadow = o_q.shadow;
    assign pwm    = o_q.pwm;
    assign strobe = o_q.strobe;
endmodule

// File: rtl/dbuf_pwm.sv
module dbuf_pwm
    import dbuf_pwm_pkg::*;
#(
    parameter int unsigned TMR_W  = 8,
    parameter int unsigned FINE_W = 2,
    parameter int unsigned PS_W   = 4,
    localparam int unsigned DUTY_W = TMR_W + FINE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [TMR_W-1:0]  bus_wdata,
    output logic [TMR_W-1:0]  bus_rdata,
    output logic              pwm_o,
    output logic              period_strobe_o
);
    logic [TMR_W-1:0]  period;
    logic [DUTY_W-1:0] duty_pend;
    logic [DUTY_W-1:0] shadow;
    logic [DUTY_W-1:0] cnt_next;
    logic [SEL_W-1:0]  sel;
    logic              ctl_en;
    logic              tick;
    logic              rollover;

    dbuf_pwm_regs #(.TMR_W(TMR_W), .FINE_W(FINE_W)) regs_i (
        .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr),
        .wdata(bus_wdata), .shadow(shadow), .rdata(bus_rdata),
        .period(period), .duty_pend(duty_pend), .en(ctl_en), .sel(sel)
    );

    dbuf_pwm_prescale #(.PS_W(PS_W)) ps_i (
        .clk(clk), .rst_n(rst_n), .en(ctl_en), .sel(sel), .tick(tick)
    );

    dbuf_pwm_timebase #(.TMR_W(TMR_W), .FINE_W(FINE_W)) tb_i (
        .clk(clk), .rst_n(rst_n), .en(ctl_en), .tick(tick),
        .period(period), .cnt_next(cnt_next), .rollover(rollover)
    );

    dbuf_pwm_out #(.DUTY_W(DUTY_W)) out_i (
        .clk(clk), .rst_n(rst_n), .en(ctl_en), .step(tick),
        .rollover(rollover), .cnt_next(cnt_next), .duty_pend(duty_pend),
        .shadow(shadow), .pwm(pwm_o), .strobe(period_strobe_o)
    );
endmodule

// File: rtl/dbuf_pwm_sva.sv
module dbuf_pwm_sva #(
    parameter int unsigned DUTY_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              en,
    input logic [DUTY_W-1:0] shadow,
    input logic              pwm,
    input logic              strobe
);
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!pwm && !strobe));

    a_r8_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!pwm && !strobe));

    a_r3_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> !strobe);

    a_r4_rise_with_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwm) |-> strobe);

    a_r5_shadow_held: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe |-> $stable(shadow));

    a_r6_zero_never_set: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && shadow == '0) |-> !pwm);
endmodule

bind dbuf_pwm dbuf_pwm_sva #(.DUTY_W(DUTY_W)) sva_i (
    .clk(clk), .rst_n(rst_n), .en(ctl_en), .shadow(shadow),
    .pwm(pwm_o), .strobe(period_strobe_o)
);

// File: tb/dbuf_pwm_tb_top.sv
module dbuf_pwm_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       pwm_o;
    logic       period_strobe_o;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    always #10 clk = ~clk;

    dbuf_pwm dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pwm_o(pwm_o), .period_strobe_o(period_strobe_o)
    );

    // {period, duty, select, expected period clocks, expected high clocks}
    localparam logic [15:0] VEC [9][5] = '{
        '{16'd9, 16'd17,  16'd0, 16'd40,  16'd17},
        '{16'd3, 16'd5,   16'd1, 16'd64,  16'd20},
        '{16'd2, 16'd7,   16'd2, 16'd192, 16'd112},
        '{16'd4, 16'd0,   16'd0, 16'd20,  16'd0},
        '{16'd4, 16'd20,  16'd0, 16'd20,  16'd20},
        '{16'd4, 16'd300, 16'd0, 16'd20,  16'd20},
        '{16'd0, 16'd3,   16'd3, 16'd64,  16'd48},
        '{16'd7, 16'd1,   16'd0, 16'd32,  16'd1},
        '{16'd4, 16'd19,  16'd0, 16'd20,  16'd19}
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output int v);
        bus_addr = a;
        #1;
        v = int'(bus_rdata);
    endtask

    // Starts at the next strobe (current sample included), returns at the following one.
    task automatic measure(output int per, output int hi);
        while (!period_strobe_o) @(negedge clk);
        per = 1;
        hi  = pwm_o ? 1 : 0;
        forever begin
            @(negedge clk);
            if (period_strobe_o) break;
            per++;
            if (pwm_o) hi++;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        int v, per, hi, bad;
        repeat (3) @(negedge clk);
        chk("R1 pwm in reset", int'(pwm_o), 0);
        chk("R1 strobe in reset", int'(period_strobe_o), 0);
        rst_n = 1'b1;
        chk("R1 pwm after reset", int'(pwm_o), 0);
        for (int a = 0; a < 6; a++) begin
            rd(3'(a), v);
            chk($sformatf("R1 reg %0d reset value", a), v, 0);
        end

        // R2 readback
        wr(3'd0, 8'd9);
        wr(3'd1, 8'hA5);
        wr(3'd2, 8'hFE);
        wr(3'd3, 8'h06);
        rd(3'd0, v); chk("R2 period readback", v, 9);
        rd(3'd1, v); chk("R2 duty high readback", v, 'hA5);
        rd(3'd2, v); chk("R2 duty low readback", v, 2);
        rd(3'd3, v); chk("R2 control readback", v, 6);

        // Vector table: R3 period, R4 high time, R6 zero duty, R7 over-long duty
        for (int i = 0; i < 9; i++) begin
            wr(3'd3, 8'h00);
            wr(3'd0, VEC[i][0][7:0]);
            wr(3'd1, VEC[i][1][9:2]);
            wr(3'd2, {6'd0, VEC[i][1][1:0]});
            wr(3'd3, {5'd0, VEC[i][2][1:0], 1'b1});
            measure(per, hi);
            chk($sformatf("R3 period vec %0d", i), per, int'(VEC[i][3]));
            chk($sformatf("R4 R6 R7 high time vec %0d", i), hi, int'(VEC[i][4]));
        end

        // R5 mid-period write: period 9, select 0, duty 10 then 30
        wr(3'd3, 8'h00);
        wr(3'd0, 8'd9);
        wr(3'd1, 8'd2);
        wr(3'd2, 8'd2);
        wr(3'd3, 8'h01);
        measure(per, hi);
        chk("R4 duty 10 high", hi, 10);
        wr(3'd1, 8'd7);
        wr(3'd2, 8'd2);
        rd(3'd4, v); chk("R5 shadow high kept", v, 2);
        rd(3'd5, v); chk("R5 shadow low kept", v, 2);
        repeat (10) @(negedge clk);
        chk("R5 old duty still drives pwm", int'(pwm_o), 0);
        measure(per, hi);
        chk("R5 new duty after strobe", hi, 30);

        // R5 write on the rollover edge: duty 30 -> 6
        repeat (39) @(negedge clk);
        wr(3'd1, 8'd1);
        measure(per, hi);
        chk("R5 collided write held back", hi, 30);
        measure(per, hi);
        chk("R5 collided write applied later", hi, 6);

        // R9 shadow is read-only
        wr(3'd4, 8'hAA);
        wr(3'd5, 8'h01);
        rd(3'd4, v); chk("R9 shadow high write ignored", v, 1);
        rd(3'd5, v); chk("R9 shadow low write ignored", v, 2);

        // R8 disable
        wr(3'd3, 8'h00);
        bad = 0;
        for (int k = 0; k < 80; k++) begin
            @(negedge clk);
            if (pwm_o || period_strobe_o) bad++;
        end
        chk("R8 quiet while disabled", bad, 0);
        wr(3'd3, 8'h01);
        measure(per, hi);
        chk("R8 timebase restarts from zero", per, 40);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule